// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block sits on the host side of a NAND flash bus and carries out one page-program operation per request. A request names a block, a page inside that block and a starting column. The sequencer first checks the request against a per-block history table. If the request passes, it sends the load command, the column and row address bytes, and then the data bytes taken from a valid/ready byte stream. A stream beat marked as a jump moves the load point to a new column in the same page, so a sparse page can be loaded in one program cycle. After the last data byte it sends the confirm command, switches the device to status output and reads status until the device reports ready or a programmable poll limit runs out. It then reports one result code.

The history table keeps, for every block, the highest page programmed so far and how many partial programs that page has received. A request for a lower page, or one more partial program than `NOP_MAX`, is refused at once and causes no bus activity. The NAND bus is shown as a one-beat-per-cycle strobe interface. `nb_we` together with `nb_cle`/`nb_ale` marks a command, address or data write on `nb_dout`. `nb_re` requests a status byte, which the device returns on `nb_din` by the next clock edge.

States: `S_IDLE` (takes a request) → `S_CHECK` (table lookup; goes to `S_DONE` on refusal or to `S_CMD_LOAD` on pass, and records the history) → `S_CMD_LOAD` → `S_ADDR` (column bytes, then row bytes) → `S_DATA`. From `S_DATA` a jump beat leads to `S_CMD_JUMP` → `S_JADDR` → back to `S_DATA`, and a last data beat leads to `S_CMD_GO` → `S_CMD_STAT` → `S_POLL_RD` ⇄ `S_POLL_EVAL`. The loop back to `S_POLL_RD` is taken while the device is busy and the limit has not run out. `S_POLL_EVAL` goes to `S_DONE` on ready or on timeout, and `S_DONE` returns to `S_IDLE`.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset `req_ready` is 1, `dat_ready`, `res_valid`, `nb_we` and `nb_re` are 0.
- R2: An accepted request drives command byte 80h with `nb_cle`=1. It is followed by `COL_BYTES` column bytes (least significant first) and then `ROW_BYTES` row bytes, all with `nb_ale`=1. The row value is `{block, page}` zero-extended, least significant byte first.
- R3: Each data beat (`dat_jump`=0) is written once, in stream order, with `nb_cle`=`nb_ale`=0. A cycle without `dat_valid` writes nothing.
- R4: A jump beat (`dat_jump`=1) writes no data. It sends command 85h and then only the `COL_BYTES` bytes of `dat_col`, with no row bytes. Loading then continues at that column.
- R5: The data beat with `dat_last`=1 is followed directly by command 10h and then command 70h.
- R6: Status is read with `nb_re` until bit 6 of the returned byte is 1. The result code is then 0 (pass) if bit 0 is 0, and 1 (program fail) if bit 0 is 1.
- R7: If `cfg_timeout` status reads in a row all show bit 6 = 0, polling stops after the last of them and the result code is 2.
- R8: A request whose page is lower than the last page programmed in that block gets result code 3, with no bus write or read.
- R9: A request for the same page as the last one in that block, made after that page has already had `NOP_MAX` programs, gets result code 4, with no bus activity.
- R10: History is kept per block. A higher page resets the partial count of that block to one, and other blocks are not affected.
- R11: `req_ready` is 0 from the cycle after a request is taken until the result. `res_valid` is a one-cycle pulse followed by `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_timeout | input | TMO_W | Maximum number of busy status reads |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_block | input | BLOCK_W | Target block |
| req_page | input | PAGE_W | Target page in block |
| req_col | input | COL_W | First column to load |
| dat_valid | input | 1 | Stream beat present |
| dat_ready | output | 1 | Stream beat taken |
| dat_jump | input | 1 | Beat is a column jump, carries no data |
| dat_last | input | 1 | Last data beat before confirm |
| dat_byte | input | 8 | Data byte |
| dat_col | input | COL_W | New column for a jump beat |
| res_valid | output | 1 | Result pulse |
| res_code | output | 3 | 0 pass, 1 fail, 2 timeout, 3 order refused, 4 count refused |
| nb_we | output | 1 | Bus write strobe |
| nb_cle | output | 1 | Write is a command |
| nb_ale | output | 1 | Write is an address byte |
| nb_dout | output | 8 | Bus write byte |
| nb_re | output | 1 | Status read strobe |
| nb_din | input | 8 | Status byte, valid the cycle after `nb_re` |

## Verification
The hardest states to reach are the refusals. A count refusal needs `NOP_MAX` earlier successful programs of the same page in the same block. An order refusal needs a higher page to have been programmed first. The stimulus table is therefore ordered as a history: two programs of one page, then a third that must be refused, then a skip to a higher page, then a return to a lower one. A second block is added between them to show that the histories stay separate. The timeout needs a device model that stays busy for longer than a small `cfg_timeout`, and the number of status reads is counted.

// File: rtl/nps_pkg.sv
package nps_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_CMD_LOAD,
        S_ADDR,
        S_DATA,
        S_CMD_JUMP,
        S_JADDR,
        S_CMD_GO,
        S_CMD_STAT,
        S_POLL_RD,
        S_POLL_EVAL,
        S_DONE
    } state_t;

    typedef enum logic [2:0] {
        RES_PASS  = 3'd0,
        RES_PFAIL = 3'd1,
        RES_TMO   = 3'd2,
        RES_ORDER = 3'd3,
        RES_NOP   = 3'd4
    } res_t;

    localparam logic [7:0] OP_LOAD = 8'h80;
    localparam logic [7:0] OP_JUMP = 8'h85;
    localparam logic [7:0] OP_GO   = 8'h10;
    localparam logic [7:0] OP_STAT = 8'h70;

    localparam int ST_READY_BIT = 6;
    localparam int ST_FAIL_BIT  = 0;

endpackage

// File: rtl/nps_rule_table.sv
module nps_rule_table
    import nps_pkg::*;
#(
    parameter int BLOCK_W = 4,
    parameter int PAGE_W  = 6,
    parameter int NOP_MAX = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BLOCK_W-1:0] chk_block,
    input  logic [PAGE_W-1:0]  chk_page,
    input  logic               upd,
    output logic               chk_ok,
    output res_t               chk_code
);
    localparam int NBLK  = 1 << BLOCK_W;
    localparam int CNT_W = $clog2(NOP_MAX + 1);

    logic              used_q [NBLK];
    logic [PAGE_W-1:0] last_q [NBLK];
    logic [CNT_W-1:0]  cnt_q  [NBLK];

    logic              cur_used;
    logic [PAGE_W-1:0] cur_last;
    logic [CNT_W-1:0]  cur_cnt;

    always_comb begin
        cur_used = used_q[chk_block];
        cur_last = last_q[chk_block];
        cur_cnt  = cnt_q[chk_block];
        chk_ok   = 1'b1;
        chk_code = RES_PASS;
        if (cur_used) begin
            if (chk_page < cur_last) begin
                chk_ok   = 1'b0;
                chk_code = RES_ORDER;
            end else if (chk_page == cur_last && cur_cnt >= CNT_W'(NOP_MAX)) begin
                chk_ok   = 1'b0;
                chk_code = RES_NOP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                used_q[b] <= 1'b0;
                last_q[b] <= '0;
                cnt_q[b]  <= '0;
            end
        end else if (upd) begin
            used_q[chk_block] <= 1'b1;
            last_q[chk_block] <= chk_page;
            if (cur_used && cur_last == chk_page)
                cnt_q[chk_block] <= cur_cnt + CNT_W'(1);
            else
                cnt_q[chk_block] <= CNT_W'(1);
        end
    end

endmodule

// File: rtl/nps_addr_gen.sv
module nps_addr_gen #(
    parameter int COL_W     = 12,
    parameter int ROW_W     = 10,
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 2,
    parameter int IDX_W     = 2
) (
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       addr_byte
);
    localparam int NADDR = COL_BYTES + ROW_BYTES;
    localparam int CBW   = COL_BYTES * 8;
    localparam int RBW   = ROW_BYTES * 8;

    logic [CBW-1:0]       col_pad;
    logic [RBW-1:0]       row_pad;
    logic [NADDR*8-1:0]   addr_vec;
    logic [7:0]           lane [NADDR];

    assign col_pad  = CBW'(col);
    assign row_pad  = RBW'(row);
    assign addr_vec = {row_pad, col_pad};

    for (genvar g = 0; g < NADDR; g++) begin : g_lane
        assign lane[g] = addr_vec[g*8 +: 8];
    end

    always_comb begin
        addr_byte = 8'h00;
        for (int k = 0; k < NADDR; k++) begin
            if (idx == IDX_W'(k))
                addr_byte = lane[k];
        end
    end

endmodule

// File: rtl/nps_poll_timer.sv
module nps_poll_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick && cnt_q != '1)
            cnt_q <= cnt_q + TMO_W'(1);
    end

    assign expired = ({1'b0, cnt_q} + (TMO_W+1)'(1)) >= {1'b0, limit};

endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
    import nps_pkg::*;
#(
    parameter int BLOCK_W   = 4,
    parameter int PAGE_W    = 6,
    parameter int COL_W     = 12,
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 2,
    parameter int NOP_MAX   = 2,
    parameter int TMO_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TMO_W-1:0]   cfg_timeout,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [BLOCK_W-1:0] req_block,
    input  logic [PAGE_W-1:0]  req_page,
    input  logic [COL_W-1:0]   req_col,
    input  logic               dat_valid,
    output logic               dat_ready,
    input  logic               dat_jump,
    input  logic               dat_last,
    input  logic [7:0]         dat_byte,
    input  logic [COL_W-1:0]   dat_col,
    output logic               res_valid,
    output logic [2:0]         res_code,
    output logic               nb_we,
    output logic               nb_cle,
    output logic               nb_ale,
    output logic [7:0]         nb_dout,
    output logic               nb_re,
    input  logic [7:0]         nb_din
);
    localparam int ROW_W = BLOCK_W + PAGE_W;
    localparam int NADDR = COL_BYTES + ROW_BYTES;
    localparam int IDX_W = (NADDR > 2) ? $clog2(NADDR) : 1;

    state_t             state_q, state_d;
    logic [BLOCK_W-1:0] blk_q;
    logic [PAGE_W-1:0]  page_q;
    logic [COL_W-1:0]   col_q;
    logic [IDX_W-1:0]   idx_q;
    res_t               code_q;

    logic               chk_ok;
    res_t               chk_code;
    logic               tbl_upd;
    logic [7:0]         addr_byte;
    logic               tmo_expired;
    logic               st_ready;
    logic               st_fail;

    assign st_ready = nb_din[ST_READY_BIT];
    assign st_fail  = nb_din[ST_FAIL_BIT];
    assign tbl_upd  = (state_q == S_CHECK) && chk_ok;

    nps_rule_table #(
        .BLOCK_W (BLOCK_W),
        .PAGE_W  (PAGE_W),
        .NOP_MAX (NOP_MAX)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_block (blk_q),
        .chk_page  (page_q),
        .upd       (tbl_upd),
        .chk_ok    (chk_ok),
        .chk_code  (chk_code)
    );

    nps_addr_gen #(
        .COL_W     (COL_W),
        .ROW_W     (ROW_W),
        .COL_BYTES (COL_BYTES),
        .ROW_BYTES (ROW_BYTES),
        .IDX_W     (IDX_W)
    ) u_addr (
        .col       (col_q),
        .row       ({blk_q, page_q}),
        .idx       (idx_q),
        .addr_byte (addr_byte)
    );

    nps_poll_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == S_CMD_GO),
        .tick    (state_q == S_POLL_EVAL),
        .limit   (cfg_timeout),
        .expired (tmo_expired)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (req_valid) state_d = S_CHECK;
            S_CHECK:     state_d = chk_ok ? S_CMD_LOAD : S_DONE;
            S_CMD_LOAD:  state_d = S_ADDR;
            S_ADDR:      if (idx_q == IDX_W'(NADDR - 1)) state_d = S_DATA;
            S_DATA: begin
                if (dat_valid) begin
                    if (dat_jump)      state_d = S_CMD_JUMP;
                    else if (dat_last) state_d = S_CMD_GO;
                end
            end
            S_CMD_JUMP:  state_d = S_JADDR;
            S_JADDR:     if (idx_q == IDX_W'(COL_BYTES - 1)) state_d = S_DATA;
            S_CMD_GO:    state_d = S_CMD_STAT;
            S_CMD_STAT:  state_d = S_POLL_RD;
            S_POLL_RD:   state_d = S_POLL_EVAL;
            S_POLL_EVAL: state_d = (st_ready || tmo_expired) ? S_DONE : S_POLL_RD;
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register and per-operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            blk_q   <= '0;
            page_q  <= '0;
            col_q   <= '0;
            idx_q   <= '0;
            code_q  <= RES_PASS;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        blk_q  <= req_block;
                        page_q <= req_page;
                        col_q  <= req_col;
                    end
                end
                S_CHECK: begin
                    idx_q  <= '0;
                    code_q <= chk_ok ? RES_PASS : chk_code;
                end
                S_ADDR, S_JADDR: idx_q <= idx_q + IDX_W'(1);
                S_DATA: begin
                    if (dat_valid && dat_jump) begin
                        col_q <= dat_col;
                        idx_q <= '0;
                    end
                end
                S_POLL_EVAL: begin
                    if (st_ready)
                        code_q <= st_fail ? RES_PFAIL : RES_PASS;
                    else if (tmo_expired)
                        code_q <= RES_TMO;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        dat_ready = (state_q == S_DATA);
        res_valid = (state_q == S_DONE);
        res_code  = code_q;
        nb_we     = 1'b0;
        nb_cle    = 1'b0;
        nb_ale    = 1'b0;
        nb_dout   = 8'h00;
        nb_re     = 1'b0;
        unique case (state_q)
            S_CMD_LOAD: begin nb_we = 1'b1; nb_cle = 1'b1; nb_dout = OP_LOAD; end
            S_CMD_JUMP: begin nb_we = 1'b1; nb_cle = 1'b1; nb_dout = OP_JUMP; end
            S_CMD_GO:   begin nb_we = 1'b1; nb_cle = 1'b1; nb_dout = OP_GO;   end
            S_CMD_STAT: begin nb_we = 1'b1; nb_cle = 1'b1; nb_dout = OP_STAT; end
            S_ADDR, S_JADDR: begin
                nb_we   = 1'b1;
                nb_ale  = 1'b1;
                nb_dout = addr_byte;
            end
            S_DATA: begin
                nb_we   = dat_valid && !dat_jump;
                nb_dout = dat_byte;
            end
            S_POLL_RD: nb_re = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/nand_prog_seq_chk.sv
module nand_prog_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       res_valid,
    input logic [2:0] res_code,
    input logic       nb_we,
    input logic       nb_cle,
    input logic       nb_ale,
    input logic [7:0] nb_dout,
    input logic       nb_re
);
    // R2: the load command is followed by an address write
    a_r2_addr_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_we && nb_cle && nb_dout == 8'h80) |=> (nb_we && nb_ale));

    // R3: a strobe carries at most one kind, and kinds only come with a write
    a_r3_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_cle || nb_ale) |-> (nb_we && !(nb_cle && nb_ale)));

    // R4: the jump command is followed by an address write
    a_r4_col_after_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_we && nb_cle && nb_dout == 8'h85) |=> (nb_we && nb_ale));

    // R5: confirm is followed directly by the status command
    a_r5_stat_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_we && nb_cle && nb_dout == 8'h10) |=> (nb_we && nb_cle && nb_dout == 8'h70));

    // R6: reads and writes never share a cycle
    a_r6_rd_wr_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nb_we, nb_re}));

    // R8, R9: a refusal is reported with no bus traffic in the cycle before
    a_r8_refuse_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code >= 3'd3) |-> (!$past(nb_we) && !$past(nb_re)));

    // R11: taking a request drops ready
    a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11: result is a single-cycle pulse
    a_r11_res_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && req_ready));

endmodule

bind nand_prog_seq nand_prog_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .res_code  (res_code),
    .nb_we     (nb_we),
    .nb_cle    (nb_cle),
    .nb_ale    (nb_ale),
    .nb_dout   (nb_dout),
    .nb_re     (nb_re)
);

// File: tb/sim_nand_prog_seq.sv
module sim_nand_prog_seq;

    typedef struct packed {
        logic [3:0]  blk;
        logic [5:0]  pg;
        logic [11:0] col;
        logic [3:0]  nb;
        logic [3:0]  jat;
        logic [11:0] jcol;
        logic [3:0]  busy;
        logic        fail;
        logic [2:0]  code;
    } vec_t;

    // history-ordered table (NOP_MAX = 2)
    localparam vec_t VEC [7] = '{
        '{4'd1, 6'd0, 12'h010, 4'd4, 4'hF, 12'h000, 4'd2, 1'b0, 3'd0}, // R2 R3 R5 R6 pass
        '{4'd1, 6'd0, 12'h1A5, 4'd3, 4'd1, 12'h7F3, 4'd0, 1'b1, 3'd1}, // R4 R6 fail, 2nd partial
        '{4'd1, 6'd0, 12'h000, 4'd2, 4'hF, 12'h000, 4'd0, 1'b0, 3'd4}, // R9 count refused
        '{4'd1, 6'd3, 12'h020, 4'd2, 4'hF, 12'h000, 4'd1, 1'b0, 3'd0}, // R10 skip up
        '{4'd2, 6'd0, 12'h300, 4'd2, 4'd0, 12'h456, 4'd3, 1'b0, 3'd0}, // R10 other block, R4 jump first
        '{4'd1, 6'd2, 12'h000, 4'd2, 4'hF, 12'h000, 4'd0, 1'b0, 3'd3}, // R8 order refused
        '{4'd1, 6'd3, 12'h040, 4'd1, 4'hF, 12'h000, 4'd0, 1'b0, 3'd0}  // R10 count restarted
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_timeout = 16'd20;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_block = '0;
    logic [5:0]  req_page = '0;
    logic [11:0] req_col = '0;
    logic        dat_valid = 1'b0;
    logic        dat_ready;
    logic        dat_jump = 1'b0;
    logic        dat_last = 1'b0;
    logic [7:0]  dat_byte = '0;
    logic [11:0] dat_col = '0;
    logic        res_valid;
    logic [2:0]  res_code;
    logic        nb_we, nb_cle, nb_ale, nb_re;
    logic [7:0]  nb_dout;
    logic [7:0]  nb_din = 8'h00;

    always #2.5 clk = ~clk;

    nand_prog_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
        .req_valid(req_valid), .req_ready(req_ready), .req_block(req_block),
        .req_page(req_page), .req_col(req_col),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_jump(dat_jump),
        .dat_last(dat_last), .dat_byte(dat_byte), .dat_col(dat_col),
        .res_valid(res_valid), .res_code(res_code),
        .nb_we(nb_we), .nb_cle(nb_cle), .nb_ale(nb_ale), .nb_dout(nb_dout),
        .nb_re(nb_re), .nb_din(nb_din)
    );

    // device model: write log and status responder
    int       log_n = 0;
    int       log_k [256];
    int       log_b [256];
    int       rd_n = 0;
    int       rd_base = 0;
    int       busy_cfg = 0;
    logic     fail_bit = 1'b0;

    always @(posedge clk) begin
        if (nb_we && log_n < 256) begin
            log_k[log_n] <= nb_cle ? 1 : (nb_ale ? 2 : 0);
            log_b[log_n] <= int'(nb_dout);
            log_n <= log_n + 1;
        end
        if (nb_re) begin
            rd_n <= rd_n + 1;
            if ((rd_n - rd_base) < busy_cfg) nb_din <= 8'h00;
            else                             nb_din <= {7'b0100000, fail_bit};
        end
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int exp_k [64];
    int exp_b [64];
    int exp_n;

    task automatic push(input int k, input int b);
        exp_k[exp_n] = k;
        exp_b[exp_n] = b;
        exp_n++;
    endtask

    task automatic send_beat(input bit jump, input bit last, input logic [7:0] b,
                             input logic [11:0] c);
        @(negedge clk);
        dat_valid = 1'b1; dat_jump = jump; dat_last = last; dat_byte = b; dat_col = c;
        while (!dat_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    // one program request; returns result code, builds expected log
    task automatic run_txn(input vec_t v, input int vi, input bit gaps, output logic [2:0] code);
        int row;
        bit refused;
        row = (int'(v.blk) << 6) | int'(v.pg);
        refused = (v.code >= 3'd3);
        exp_n = 0;
        @(negedge clk);
        busy_cfg = int'(v.busy);
        fail_bit = v.fail;
        rd_base  = rd_n;
        req_valid = 1'b1; req_block = v.blk; req_page = v.pg; req_col = v.col;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 ready low while busy", int'(req_ready), 0);
        if (!refused) begin
            push(1, 8'h80);
            push(2, int'(v.col[7:0])); push(2, int'(v.col[11:8]));
            push(2, row & 8'hFF);      push(2, (row >> 8) & 8'hFF);
            for (int i = 0; i < int'(v.nb); i++) begin
                logic [7:0] b;
                b = 8'(8'hA0 + vi * 16 + i);
                if (i == int'(v.jat)) begin
                    push(1, 8'h85);
                    push(2, int'(v.jcol[7:0])); push(2, int'(v.jcol[11:8]));
                    send_beat(1'b1, 1'b0, 8'hEE, v.jcol);
                end
                push(0, int'(b));
                send_beat(1'b0, i == int'(v.nb) - 1, b, 12'h000);
                if (gaps && (i % 2 == 1)) @(negedge clk);
            end
            push(1, 8'h10);
            push(1, 8'h70);
        end
        while (!res_valid) @(negedge clk);
        code = res_code;
        @(negedge clk);
        chk(res_valid == 1'b0 && req_ready == 1'b1, "R11 result pulse", int'(res_valid), 0);
    endtask

    task automatic cmp_log(input int base, input string req);
        bit ok;
        ok = (log_n - base) == exp_n;
        chk(ok, {req, " write count"}, log_n - base, exp_n);
        if (ok) begin
            for (int i = 0; i < exp_n; i++) begin
                if (log_k[base + i] != exp_k[i] || log_b[base + i] != exp_b[i]) begin
                    chk(1'b0, {req, " write sequence"}, log_b[base + i], exp_b[i]);
                    return;
                end
            end
            chk(1'b1, req, 0, 0);
        end
    endtask

    initial begin
        logic [2:0] code;
        int base;
        int reads;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
        chk(dat_ready == 1'b0, "R1 dat_ready", int'(dat_ready), 0);
        chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
        chk(nb_we == 1'b0 && nb_re == 1'b0, "R1 bus idle", int'({nb_we, nb_re}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && nb_we == 1'b0, "R1 idle after release", int'(req_ready), 1);

        // table walk: R2..R6, R8..R10
        for (int vi = 0; vi < 7; vi++) begin
            base = log_n;
            run_txn(VEC[vi], vi, vi[0], code);
            chk(code == VEC[vi].code, $sformatf("R6 R8 R9 R10 result vec %0d", vi),
                int'(code), int'(VEC[vi].code));
            cmp_log(base, $sformatf("R2 R3 R4 R5 bus vec %0d", vi));
            if (VEC[vi].code >= 3'd3)
                chk(rd_n == rd_base, "R8 R9 no status read", rd_n - rd_base, 0);
        end

        // R7: device stays busy past the limit
        cfg_timeout = 16'd3;
        base = log_n;
        run_txn('{4'd3, 6'd0, 12'h000, 4'd2, 4'hF, 12'h000, 4'd10, 1'b0, 3'd2}, 9, 1'b0, code);
        reads = rd_n - rd_base;
        chk(code == 3'd2, "R7 timeout code", int'(code), 2);
        chk(reads == 3, "R7 status reads", reads, 3);
        cmp_log(base, "R7 bus");

        // R6: ready on the last permitted read still passes
        base = log_n;
        run_txn('{4'd4, 6'd1, 12'h000, 4'd1, 4'hF, 12'h000, 4'd2, 1'b0, 3'd0}, 10, 1'b0, code);
        chk(code == 3'd0, "R6 ready at limit", int'(code), 0);
        chk(rd_n - rd_base == 3, "R6 reads at limit", rd_n - rd_base, 3);

        // R3: long stall before a data beat writes nothing
        cfg_timeout = 16'd20;
        base = log_n;
        @(negedge clk);
        busy_cfg = 0; fail_bit = 1'b0; rd_base = rd_n;
        req_valid = 1'b1; req_block = 4'd5; req_page = 6'd0; req_col = 12'h000;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(log_n - base == 5, "R3 stall writes nothing", log_n - base, 5);
        send_beat(1'b0, 1'b1, 8'h5A, 12'h000);
        while (!res_valid) @(negedge clk);
        chk(res_code == 3'd0, "R3 stall result", int'(res_code), 0);
        chk(log_n - base == 8 && log_b[base + 5] == 8'h5A && log_k[base + 5] == 0,
            "R3 stalled byte", log_b[base + 5], 8'h5A);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule